// File: doc/BRIEF.md
# Widening Vector Operand Legality Checker

This block sits in the decode stage of a vector unit. It screens the register operands of widening arithmetic instructions, which read single-width or double-width sources and always write a double-width result. For each decoded instruction it receives the operand form, the masked flag, the three vector register numbers and the current register-grouping factor (LMUL). From the element width of each operand it derives that operand's register-group size. It then checks the alignment of every group and the overlaps between groups.

The result is registered. One cycle after a decode-valid strobe, the block presents a one-cycle result-valid pulse, an illegal-instruction flag and a reason code. Between strobes the last result is held. When several checks fail in the same instruction, a fixed priority picks which one the reason code reports.

Top module: `wvchk_top`

## Requirements
- R1: `chk_valid_o` pulses high exactly one cycle after `dec_valid_i` is high, and is low otherwise. `illegal_o` and `reason_o` are loaded only on a strobe and keep their value in every other cycle. After reset all three outputs are 0.
- R2: LMUL is encoded as its base-2 logarithm on `lmul_i` (0 means 1 register, 3 means 8 registers). When `lmul_i` is 3, the instruction is always illegal with reason 1, because the destination would need 16 registers.
- R3: The destination group is 2*LMUL registers. If `vd_i` is not a multiple of 2*LMUL, the reason is 1 (destination invalid).
- R4: `form_i` encodes 0 = vv, 1 = vx, 2 = wv, 3 = wx. In vv and vx, `vs2_i` must be a multiple of LMUL. In wv and wx, it is double-width and must be a multiple of 2*LMUL. A misaligned `vs2_i` gives reason 2 (source misaligned).
- R5: In vv and wv, `vs1_i` is a single-width group and must be a multiple of LMUL, otherwise the reason is 2. In vx and wx, `vs1_i` names a scalar register and has no effect on the result.
- R6: Register groups occupy [base, base+size-1]. If the destination group intersects a single-width source group, the reason is 3 (overlap). The single-width sources are `vs2_i` in vv/vx and `vs1_i` in vv/wv.
- R7: In wv and wx, the double-width `vs2_i` group may share registers with the destination, including `vd_i` equal to `vs2_i`. This raises no overlap.
- R8: When `masked_i` is 1 and the destination group contains register 0 (the mask register), the reason is 4 (mask overlap). When `masked_i` is 0, this check is skipped.
- R9: When several checks fail, the reason reported is the first in the order 1, 2, 3, 4. `illegal_o` is 1 exactly when `reason_o` is nonzero.
- R10: An instruction that passes every check gives `illegal_o` = 0 and `reason_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| dec_valid_i | input | 1 | Decode strobe: operands are valid this cycle |
| form_i | input | 2 | Operand form: 0 vv, 1 vx, 2 wv, 3 wx |
| masked_i | input | 1 | Instruction is masked by register 0 |
| vd_i | input | 5 | Destination register number |
| vs2_i | input | 5 | First source register number |
| vs1_i | input | 5 | Second source register number (scalar in vx/wx) |
| lmul_i | input | 2 | log2 of LMUL |
| chk_valid_o | output | 1 | Result valid, one cycle after the strobe |
| illegal_o | output | 1 | Instruction operands are illegal |
| reason_o | output | 3 | 0 ok, 1 destination, 2 source misaligned, 3 overlap, 4 mask overlap |

## Verification
The bench builds the block with its default parameters: 32 vector registers and a 2-bit LMUL code. With these values an exhaustive sweep is affordable. It runs every form, every LMUL code, both mask settings, every destination number, a stride of first-source numbers and several second-source numbers. This covers every alignment boundary, every partial and full group intersection and every combination of failures that tests the priority order. Directed cases with no strobe in between confirm that the result is held between strobes and that the scalar operand is ignored.

// File: rtl/wvchk_pkg.sv
package wvchk_pkg;

    typedef enum logic [1:0] {
        FORM_VV = 2'd0,
        FORM_VX = 2'd1,
        FORM_WV = 2'd2,
        FORM_WX = 2'd3
    } wform_e;

    typedef enum logic [2:0] {
        RSN_NONE = 3'd0,
        RSN_DST  = 3'd1,
        RSN_SRC  = 3'd2,
        RSN_OVL  = 3'd3,
        RSN_MASK = 3'd4
    } rsn_e;

    typedef struct packed {
        logic       valid;
        logic       illegal;
        logic [2:0] reason;
    } chk_res_t;

    localparam int NUM_SRC_CHK = 3;

endpackage

// File: rtl/wvchk_align.sv
module wvchk_align #(
    parameter int RW   = 5,
    parameter int SL_W = 3
) (
    input  logic [RW-1:0]   base_i,
    input  logic [SL_W-1:0] log_i,
    output logic            ok_o
);
    localparam int EW = RW + 1;

    logic [EW-1:0] low_mask;

    always_comb begin
        low_mask = ({{(EW-1){1'b0}}, 1'b1} << log_i) - {{(EW-1){1'b0}}, 1'b1};
        ok_o     = (({1'b0, base_i}) & low_mask) == '0;
    end
endmodule

// File: rtl/wvchk_overlap.sv
module wvchk_overlap #(
    parameter int RW   = 5,
    parameter int SL_W = 3
) (
    input  logic [RW-1:0]   a_base_i,
    input  logic [SL_W-1:0] a_log_i,
    input  logic [RW-1:0]   b_base_i,
    input  logic [SL_W-1:0] b_log_i,
    output logic            hit_o
);
    localparam int EW = RW + 2;

    logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [EW-1:0] one;

    always_comb begin
        one  = {{(EW-1){1'b0}}, 1'b1};
        a_lo = {2'b00, a_base_i};
        b_lo = {2'b00, b_base_i};
        a_hi = a_lo + (one << a_log_i) - one;
        b_hi = b_lo + (one << b_log_i) - one;
        hit_o = (a_lo <= b_hi) && (b_lo <= a_hi);
    end
endmodule

// File: rtl/wvchk_prio.sv
module wvchk_prio
    import wvchk_pkg::*;
(
    input  logic       dst_bad_i,
    input  logic       src_bad_i,
    input  logic       ovl_i,
    input  logic       mask_bad_i,
    output logic       illegal_o,
    output logic [2:0] reason_o
);
    rsn_e rsn;

    always_comb begin
        if (dst_bad_i)       rsn = RSN_DST;
        else if (src_bad_i)  rsn = RSN_SRC;
        else if (ovl_i)      rsn = RSN_OVL;
        else if (mask_bad_i) rsn = RSN_MASK;
        else                 rsn = RSN_NONE;
        reason_o  = rsn;
        illegal_o = dst_bad_i | src_bad_i | ovl_i | mask_bad_i;
    end
endmodule

// File: rtl/wvchk_top.sv
module wvchk_top
    import wvchk_pkg::*;
#(
    parameter int NUM_VREG = 32,
    parameter int LMUL_W   = 2,
    localparam int RW      = $clog2(NUM_VREG)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dec_valid_i,
    input  logic [1:0]        form_i,
    input  logic              masked_i,
    input  logic [RW-1:0]     vd_i,
    input  logic [RW-1:0]     vs2_i,
    input  logic [RW-1:0]     vs1_i,
    input  logic [LMUL_W-1:0] lmul_i,
    output logic              chk_valid_o,
    output logic              illegal_o,
    output logic [2:0]        reason_o
);
    localparam int SL_W = LMUL_W + 1;
    localparam logic [LMUL_W-1:0] LMUL_TOP = {LMUL_W{1'b1}};

    // operand attributes
    logic            is_wide;
    logic            vs1_vec;
    logic [SL_W-1:0] s_log;
    logic [SL_W-1:0] d_log;
    logic [SL_W-1:0] vs2_log;

    always_comb begin
        is_wide = (form_i == FORM_WV) || (form_i == FORM_WX);
        vs1_vec = (form_i == FORM_VV) || (form_i == FORM_WV);
        s_log   = {1'b0, lmul_i};
        d_log   = s_log + {{(SL_W-1){1'b0}}, 1'b1};
        vs2_log = is_wide ? d_log : s_log;
    end

    // alignment
    logic vd_al, vs2_al, vs1_al;

    wvchk_align #(.RW(RW), .SL_W(SL_W)) u_al_vd  (.base_i(vd_i),  .log_i(d_log),   .ok_o(vd_al));
    wvchk_align #(.RW(RW), .SL_W(SL_W)) u_al_vs2 (.base_i(vs2_i), .log_i(vs2_log), .ok_o(vs2_al));
    wvchk_align #(.RW(RW), .SL_W(SL_W)) u_al_vs1 (.base_i(vs1_i), .log_i(s_log),   .ok_o(vs1_al));

    // overlap against destination: 0 = vs2, 1 = vs1, 2 = mask register
    logic [RW-1:0]   ov_base [NUM_SRC_CHK];
    logic [SL_W-1:0] ov_log  [NUM_SRC_CHK];
    logic [NUM_SRC_CHK-1:0] ov_hit;

    always_comb begin
        ov_base[0] = vs2_i;
        ov_log[0]  = vs2_log;
        ov_base[1] = vs1_i;
        ov_log[1]  = s_log;
        ov_base[2] = '0;
        ov_log[2]  = '0;
    end

    for (genvar g = 0; g < NUM_SRC_CHK; g++) begin : g_ovl
        wvchk_overlap #(.RW(RW), .SL_W(SL_W)) u_ovl (
            .a_base_i (vd_i),
            .a_log_i  (d_log),
            .b_base_i (ov_base[g]),
            .b_log_i  (ov_log[g]),
            .hit_o    (ov_hit[g])
        );
    end

    // check combination
    logic dst_bad, src_bad, ovl_bad, mask_bad;

    always_comb begin
        dst_bad  = (lmul_i == LMUL_TOP) || !vd_al;
        src_bad  = !vs2_al || (vs1_vec && !vs1_al);
        ovl_bad  = (!is_wide && ov_hit[0]) || (vs1_vec && ov_hit[1]);
        mask_bad = masked_i && ov_hit[2];
    end

    logic       prio_illegal;
    logic [2:0] prio_reason;

    wvchk_prio u_prio (
        .dst_bad_i  (dst_bad),
        .src_bad_i  (src_bad),
        .ovl_i      (ovl_bad),
        .mask_bad_i (mask_bad),
        .illegal_o  (prio_illegal),
        .reason_o   (prio_reason)
    );

    // two-process result register
    chk_res_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = dec_valid_i;
        if (dec_valid_i) begin
            res_d.illegal = prio_illegal;
            res_d.reason  = prio_reason;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign chk_valid_o = res_q.valid;
    assign illegal_o   = res_q.illegal;
    assign reason_o    = res_q.reason;

endmodule

// File: rtl/wvchk_sva.sv
module wvchk_sva #(
    parameter int NUM_VREG = 32,
    parameter int LMUL_W   = 2,
    localparam int RW      = $clog2(NUM_VREG)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              dec_valid_i,
    input logic [1:0]        form_i,
    input logic              masked_i,
    input logic [RW-1:0]     vd_i,
    input logic [RW-1:0]     vs2_i,
    input logic [RW-1:0]     vs1_i,
    input logic [LMUL_W-1:0] lmul_i,
    input logic              chk_valid_o,
    input logic              illegal_o,
    input logic [2:0]        reason_o
);
    localparam logic [LMUL_W-1:0] LMUL_TOP = {LMUL_W{1'b1}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |=> chk_valid_o); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec_valid_i |=> !chk_valid_o); // R1
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dec_valid_i |=> ($stable(reason_o) && $stable(illegal_o))); // R1
    AST_LMUL_TOP_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && lmul_i == LMUL_TOP) |=> (illegal_o && reason_o == 3'd1)); // R2
    AST_MASK_V0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_i && masked_i && vd_i == '0) |=> illegal_o); // R8
    AST_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o == (reason_o != 3'd0)); // R9
    AST_REASON_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reason_o <= 3'd4); // R9
endmodule

bind wvchk_top wvchk_sva #(.NUM_VREG(NUM_VREG), .LMUL_W(LMUL_W)) u_sva (.*);

// File: tb/wvchk_top_tb_top.sv
module wvchk_top_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       dec_valid_i = 1'b0;
    logic [1:0] form_i = '0;
    logic       masked_i = 1'b0;
    logic [4:0] vd_i = '0;
    logic [4:0] vs2_i = '0;
    logic [4:0] vs1_i = '0;
    logic [1:0] lmul_i = '0;
    logic       chk_valid_o;
    logic       illegal_o;
    logic [2:0] reason_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    reason;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk_i = ~clk_i;

    wvchk_top dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dec_valid_i (dec_valid_i),
        .form_i      (form_i),
        .masked_i    (masked_i),
        .vd_i        (vd_i),
        .vs2_i       (vs2_i),
        .vs1_i       (vs1_i),
        .lmul_i      (lmul_i),
        .chk_valid_o (chk_valid_o),
        .illegal_o   (illegal_o),
        .reason_o    (reason_o)
    );

    // Reference: register sets as bitmaps
    function automatic logic [63:0] grp_set(int base, int size);
        logic [63:0] s = '0;
        for (int k = 0; k < size; k++) s[base + k] = 1'b1;
        return s;
    endfunction

    function automatic int ref_reason(int f, int m, int vd, int vs2, int vs1, int lg);
        int  l    = 1 << lg;
        bit  wide = (f >= 2);
        bit  v1   = (f == 0) || (f == 2);
        int  w2   = wide ? 2 * l : l;
        logic [63:0] dset, s2, s1;
        if (lg == 3 || (vd % (2 * l)) != 0) return 1;       // R2 R3
        if ((vs2 % w2) != 0 || (v1 && (vs1 % l) != 0)) return 2; // R4 R5
        dset = grp_set(vd, 2 * l);
        s2   = grp_set(vs2, w2);
        s1   = grp_set(vs1, l);
        if ((!wide && |(dset & s2)) || (v1 && |(dset & s1))) return 3; // R6 R7
        if (m != 0 && dset[0]) return 4;                     // R8
        return 0;                                            // R10
    endfunction

    function automatic string tag_of(int r);
        case (r)
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(int f, int m, int vd, int vs2, int vs1, int lg, string tag);
        exp_t e;
        @(negedge clk_i);
        form_i = 2'(f); masked_i = m[0]; vd_i = 5'(vd); vs2_i = 5'(vs2);
        vs1_i = 5'(vs1); lmul_i = 2'(lg); dec_valid_i = 1'b1;
        e.reason = ref_reason(f, m, vd, vs2, vs1, lg);
        e.tag    = (tag == "") ? tag_of(e.reason) : tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(int n, bit scramble);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            dec_valid_i = 1'b0;
            if (scramble) begin
                vd_i = 5'd1; vs2_i = 5'd3; lmul_i = 2'd3; masked_i = 1'b1;
            end
        end
    endtask

    // Monitor / scoreboard
    int last_reason = 0;
    initial begin
        @(posedge rst_ni);
        forever begin
            @(posedge clk_i);
            #2;
            if (chk_valid_o) begin
                exp_t e;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1: valid without strobe, actual 1 expected 0");
                end else begin
                    e = exp_q.pop_front();
                    if (int'(reason_o) != e.reason || illegal_o != (e.reason != 0)) begin
                        errors++;
                        $display("FAIL %s R9: actual reason %0d illegal %0d expected reason %0d illegal %0d",
                                 e.tag, reason_o, illegal_o, e.reason, (e.reason != 0));
                    end
                    last_reason = e.reason;
                end
            end else begin
                checks++;
                if (int'(reason_o) != last_reason) begin
                    errors++;
                    $display("FAIL R1: held reason actual %0d expected %0d", reason_o, last_reason);
                end
            end
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk_i);
        #2;
        checks++;
        if (chk_valid_o !== 1'b0 || illegal_o !== 1'b0 || reason_o !== 3'd0) begin
            errors++;
            $display("FAIL R1: reset outputs actual %0d/%0d/%0d expected 0/0/0",
                     chk_valid_o, illegal_o, reason_o);
        end
        @(negedge clk_i);
        rst_ni = 1'b1;

        drive(0, 0, 4, 8, 10, 1, "R10");  // legal vv LMUL 2
        drive(1, 0, 0, 8, 0, 3, "R2");    // LMUL 8
        drive(0, 0, 2, 8, 10, 1, "R3");   // vd not multiple of 4
        drive(2, 0, 4, 2, 9, 1, "R4");    // wide vs2 aligned to 2 only
        drive(0, 0, 4, 9, 10, 1, "R4");   // single vs2 misaligned
        drive(0, 0, 4, 8, 11, 1, "R5");   // vs1 misaligned
        drive(1, 0, 4, 8, 11, 1, "R5");   // vx ignores vs1
        drive(3, 0, 8, 0, 9, 1, "R5");    // wx ignores vs1
        drive(0, 0, 4, 6, 10, 1, "R6");   // vs2 inside vd group
        drive(2, 0, 8, 0, 10, 1, "R6");   // vs1 inside vd group in wv
        drive(2, 0, 4, 4, 10, 1, "R7");   // vd == vs2 wv legal
        drive(3, 0, 8, 8, 1, 2, "R7");    // vd == vs2 wx legal
        drive(0, 1, 0, 8, 10, 0, "R8");   // masked vd v0
        drive(0, 0, 0, 8, 10, 0, "R8");   // unmasked same: legal
        drive(0, 1, 2, 2, 3, 1, "R9");    // dst beats others
        drive(0, 1, 0, 1, 2, 0, "R9");    // overlap beats mask
        drive(0, 1, 0, 3, 4, 0, "R9");    // src ok, no ovl, mask only
        drive(2, 1, 1, 4, 4, 0, "R9");    // src misaligned? vs2 wide needs 2 -> ok; dst bad
        idle(3, 1'b1);                    // R1 hold while inputs change
        drive(0, 0, 4, 8, 10, 1, "R10");
        idle(2, 1'b0);

        for (int f = 0; f < 4; f++)
            for (int lg = 0; lg < 4; lg++)
                for (int m = 0; m < 2; m++)
                    for (int vd = 0; vd < 32; vd++)
                        for (int vs2 = 0; vs2 < 32; vs2 += 3)
                            for (int k = 0; k < 3; k++)
                                drive(f, m, vd, vs2, (k == 0) ? 0 : ((k == 1) ? 2 : 8), lg, "");
        idle(4, 1'b0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: pending results actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule